// File: doc/BRIEF.md
# Single-Precision Compare with Operand Class Flags

This block takes two IEEE-754 binary32 operands and reports how they relate. The answer is a one-hot relation code, not a single true/false bit, so one compare serves every relational test a consumer may want. Two further bits in the same vector say whether each operand was a subnormal (denormal) number. Subnormals are compared at their exact value and are never flushed to zero.

The compare is quiet. A quiet NaN on either side gives the unordered code and raises no exception. A signalling NaN also gives unordered and raises the invalid-operation flag. Operands are sampled when `in_valid` is high. The result vector and the invalid flag appear together one clock later, marked by `out_valid`.

Top module: `fcmp_class`

## Requirements
- R1: When `out_valid` is high, exactly one of `result[3:0]` is set. Bit 0 means a < b, bit 1 means a == b, bit 2 means a > b and bit 3 means unordered.
- R2: For ordered, finite, positive operands, the relation bit follows numeric order.
- R3: +0 and -0 compare equal in either order, and each compares equal to itself.
- R4: For ordered operands of differing sign, the negative one is the smaller. Two negative operands are ordered in reverse of their magnitudes.
- R5: `result[4]` is set when operand a is denormal, and `result[5]` is set when operand b is denormal. An operand is denormal when its exponent field (bits 30:23) is zero and its fraction field (bits 22:0) is non-zero.
- R6: Denormal operands are compared at their true magnitude. The smallest positive denormal is greater than +0 and smaller than the smallest normal number.
- R7: A quiet NaN has exponent all ones and fraction bit 22 set. A quiet NaN on either input gives the unordered code with `invalid` low.
- R8: A signalling NaN has exponent all ones, fraction bit 22 clear and a non-zero fraction. A signalling NaN on either input gives the unordered code with `invalid` high.
- R9: Infinities are ordered. +inf is greater than every finite value, -inf is smaller than every finite value, and each infinity equals itself.
- R10: `out_valid` is `in_valid` delayed by one clock, and `result` and `invalid` belong to the operands sampled on that same edge. When `in_valid` is low, `invalid` is low on the next cycle and `result` keeps its last value.
- R11: While reset (`rst_n` low, asynchronous) is asserted, `out_valid`, `result` and `invalid` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| op_a | input | 32 | First operand, binary32 |
| op_b | input | 32 | Second operand, binary32 |
| out_valid | output | 1 | Result present this cycle |
| result | output | 6 | [3:0] one-hot relation, [4] a denormal, [5] b denormal |
| invalid | output | 1 | Signalling NaN seen in the compared pair |

## Verification
The embedded properties assume that `in_valid` is never X after reset and that operands are stable for the whole cycle in which they are sampled. They also assume that a held `result` is only meaningful while `out_valid` is high. The bench drives new operands on the falling edge and raises `in_valid` only with fully defined bit patterns. It sweeps every ordered pair from a fixed set of class representatives: both zeros, extreme denormals, normals, infinities, and both NaN kinds with both signs. It then adds random pairs and near-neighbour pairs whose expected relation comes from a signed-integer mapping of the encodings.

// File: rtl/fcmp_class.sv
module fcmp_class #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [EXP_W+FRAC_W:0]         op_a,
  input  logic [EXP_W+FRAC_W:0]         op_b,
  output logic                          out_valid,
  output logic [5:0]                    result,
  output logic                          invalid
);
  localparam int W   = 1 + EXP_W + FRAC_W;
  localparam int MAG = EXP_W + FRAC_W;

  logic               sgn_a, sgn_b;
  logic [EXP_W-1:0]   exp_a, exp_b;
  logic [FRAC_W-1:0]  frc_a, frc_b;
  logic [MAG-1:0]     mag_a, mag_b;

  assign sgn_a = op_a[W-1];
  assign sgn_b = op_b[W-1];
  assign exp_a = op_a[MAG-1:FRAC_W];
  assign exp_b = op_b[MAG-1:FRAC_W];
  assign frc_a = op_a[FRAC_W-1:0];
  assign frc_b = op_b[FRAC_W-1:0];
  assign mag_a = op_a[MAG-1:0];
  assign mag_b = op_b[MAG-1:0];

  logic nan_a, nan_b, snan_a, snan_b, den_a, den_b, both_zero;
  assign nan_a     = (&exp_a) && (|frc_a);
  assign nan_b     = (&exp_b) && (|frc_b);
  assign snan_a    = nan_a && !frc_a[FRAC_W-1];
  assign snan_b    = nan_b && !frc_b[FRAC_W-1];
  assign den_a     = (exp_a == '0) && (|frc_a);
  assign den_b     = (exp_b == '0) && (|frc_b);
  assign both_zero = (mag_a == '0) && (mag_b == '0);

  logic mag_lt, mag_eq;
  assign mag_lt = mag_a < mag_b;
  assign mag_eq = mag_a == mag_b;

  logic [3:0] rel;
  always_comb begin
    if (nan_a || nan_b)
      rel = 4'b1000;
    else if (both_zero || (mag_eq && sgn_a == sgn_b))
      rel = 4'b0010;
    else if (sgn_a != sgn_b)
      rel = sgn_a ? 4'b0001 : 4'b0100;
    else if (mag_lt ^ sgn_a)
      rel = 4'b0001;
    else
      rel = 4'b0100;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      invalid   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      invalid   <= in_valid && (snan_a || snan_b);
      if (in_valid)
        result <= {den_b, den_a, rel};
    end
  end

  // R1
  onehot_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(result[3:0]) == 1);

  // R8
  invalid_unord_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> (out_valid && result[3]));

  // R10
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R10
  idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !invalid && $stable(result)));

  // R6
  den_ordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && result[4] && result[5]) |-> !result[3]);

  // R3
  same_bits_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_a == op_b && !(&op_a[MAG-1:FRAC_W])) |=> result[1]);
endmodule

// File: tb/fcmp_class_tb.sv
module fcmp_class_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        out_valid;
  logic [5:0]  result;
  logic        invalid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fcmp_class u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result), .invalid(invalid)
  );

  function automatic logic [31:0] rep(input int i);
    case (i)
      0:  rep = 32'h00000000;  1:  rep = 32'h80000000;
      2:  rep = 32'h00000001;  3:  rep = 32'h80000001;
      4:  rep = 32'h007fffff;  5:  rep = 32'h807fffff;
      6:  rep = 32'h00800000;  7:  rep = 32'h3f800000;
      8:  rep = 32'hbf800000;  9:  rep = 32'h3fc00000;
      10: rep = 32'hc0000000;  11: rep = 32'h7f7fffff;
      12: rep = 32'hff7fffff;  13: rep = 32'h7f800000;
      14: rep = 32'hff800000;  15: rep = 32'h7fc00000;
      16: rep = 32'hffc00001;  17: rep = 32'h7f800001;
      18: rep = 32'hffa00000;  default: rep = 32'h3f800001;
    endcase
  endfunction

  function automatic bit is_nan(input logic [31:0] v);
    return (v[30:23] == 8'hff) && (v[22:0] != 0);
  endfunction
  function automatic bit is_snan(input logic [31:0] v);
    return is_nan(v) && !v[22];
  endfunction
  function automatic bit is_den(input logic [31:0] v);
    return (v[30:23] == 8'h00) && (v[22:0] != 0);
  endfunction
  function automatic logic signed [33:0] key(input logic [31:0] v);
    logic signed [33:0] m;
    m = $signed({3'b000, v[30:0]});
    return v[31] ? -m : m;
  endfunction

  function automatic logic [3:0] exp_rel(input logic [31:0] a, input logic [31:0] b);
    if (is_nan(a) || is_nan(b)) return 4'b1000;
    if (key(a) < key(b)) return 4'b0001;
    if (key(a) > key(b)) return 4'b0100;
    return 4'b0010;
  endfunction

  function automatic string tag(input logic [31:0] a, input logic [31:0] b);
    if (is_snan(a) || is_snan(b)) return "R8";
    if (is_nan(a) || is_nan(b)) return "R7";
    if (a[30:0] == 0 && b[30:0] == 0) return "R3";
    if (is_den(a) || is_den(b)) return "R6";
    if (a[30:23] == 8'hff || b[30:23] == 8'hff) return "R9";
    if (a[31] || b[31]) return "R4";
    return "R2";
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, op_a, op_b, act, expv);
    end
  endtask

  task automatic one(input logic [31:0] a, input logic [31:0] b);
    logic [5:0] e;
    @(negedge clk);
    op_a = a; op_b = b; in_valid = 1'b1;
    e = {is_den(b), is_den(a), exp_rel(a, b)};
    @(posedge clk); #1;
    check(out_valid == 1'b1, "R10", {31'd0, out_valid}, 32'd1);
    check(result[3:0] == e[3:0], tag(a, b), {28'd0, result[3:0]}, {28'd0, e[3:0]});
    check($countones(result[3:0]) == 1, "R1", {28'd0, result[3:0]}, {28'd0, e[3:0]});
    check(result[5:4] == e[5:4], "R5", {30'd0, result[5:4]}, {30'd0, e[5:4]});
    check(invalid == (is_snan(a) || is_snan(b)), is_snan(a) || is_snan(b) ? "R8" : "R7",
          {31'd0, invalid}, {31'd0, is_snan(a) || is_snan(b)});
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] held;
    repeat (3) @(negedge clk);
    check(out_valid == 0 && result == 0 && invalid == 0, "R11",
          {25'd0, out_valid, result}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 0 && result == 0 && invalid == 0, "R11",
          {24'd0, invalid, out_valid, result}, 32'd0);

    for (int i = 0; i < 20; i++)
      for (int j = 0; j < 20; j++)
        one(rep(i), rep(j));

    one(32'h80000000, 32'h00000000);
    check(result[1] == 1'b1, "R3", {28'd0, result[3:0]}, 32'd2);
    one(32'h00000001, 32'h00800000);
    check(result[0] == 1'b1, "R6", {28'd0, result[3:0]}, 32'd1);

    for (int k = 0; k < 3000; k++) begin
      logic [31:0] a;
      a = $urandom;
      case (k % 4)
        0: one(a, $urandom);
        1: one(a, a + 32'd1);
        2: one(a, a ^ 32'h80000000);
        default: one({a[31], 8'h00, a[22:0]}, {a[31] ^ a[0], 8'h00, a[22:1], 1'b1});
      endcase
    end

    one(32'h7f800001, 32'h3f800000);
    held = result;
    @(negedge clk);
    in_valid = 1'b0; op_a = 32'h00000000; op_b = 32'h3f800000;
    @(posedge clk); #1;
    check(out_valid == 1'b0, "R10", {31'd0, out_valid}, 32'd0);
    check(invalid == 1'b0, "R10", {31'd0, invalid}, 32'd0);
    check(result == held, "R10", {26'd0, result}, {26'd0, held});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule